// File: doc/BRIEF.md
# MAC address hash filter

This block decides whether a 48-bit destination MAC address is one the receiver should take. The accepted addresses live in a local table of 2048 entries, each 64 bits wide. An entry holds a valid flag, a skip flag, a receive-discard flag and the full address. A lookup turns the address into an 11-bit table index with a fixed hash. It then reads entries one per clock cycle, starting at that index and moving to the next higher index, wrapping from the last entry to the first. The walk stops at the first empty entry (a miss), at the first entry holding the same address (a hit), or after a parameterised number of reads.

The same port also inserts and deletes addresses, and both use the same walk. An insert fills the first empty or matching entry, or reports that the table is full. A delete zeroes the matching entry. A separate clear command zeroes the whole table, one entry per cycle. Requests are only taken once a clear has completed after reset. Each request ends with a one-cycle `done` pulse, which carries the hit and full outcome and, for a lookup hit, the stored skip and discard flags.

Top module: `mac_hash_filter`

## Requirements
- R1: After reset `ready` and `done` are low. Requests are ignored, and the table is not written, until a clear command has completed.
- R2: A clear command taken while the block is idle writes zero to all 2048 entries. `ready` rises exactly 2048 clock edges after the edge that took the command, and every address looked up afterwards misses.
- R3: The start index is computed as follows. Reverse the bit order inside every byte of the address. Let L be the reversed low 32 bits and h0 the reversed bit 0 of the high part; h0 equals original address bit 39. Form f0 = L[7:2], f1 = {L[14:8],L[1:0]}, f2 = L[23:15] and f3 = {h0,L[31:24]}. The index is the low 11 bits of {f0, f1^f2^f3}.
- R4: A lookup ends as a hit when it reaches a valid entry holding the same 48-bit address. It then reports that entry's skip flag on `rsp_skip` and its discard flag on `rsp_discard`. It ends as a miss at an empty entry. `rsp_skip` and `rsp_discard` are low except on a lookup hit.
- R5: Entries are read at consecutive indices, one per cycle. When the walk ends at its P-th read, `done` is high in the cycle after the P-th rising edge that follows the accepting edge.
- R6: The walk continues from index 2047 to index 0.
- R7: After HOP_LIMIT reads of valid, non-matching entries the request ends. A lookup or delete reports a miss, and an insert reports `full` and writes nothing. `done` appears HOP_LIMIT edges after acceptance.
- R8: An insert writes {address, discard, skip, valid=1} into the first empty or matching entry. `hit` is 1 when an existing entry was overwritten and 0 when an empty entry was used.
- R9: A delete zeroes the matching entry and reports `hit`=1. An absent address leaves the table unchanged and gives `hit`=0. A later walk stops at the zeroed entry as if it were empty.
- R10: `req_op` encodes 2'b00 lookup, 2'b01 insert, 2'b10 delete; 2'b11 acts as a lookup. A request is taken only while `ready` is high. When `clr_start` and `req_valid` are high on the same edge, the clear is taken and the request is dropped.
- R11: `done` is a single-cycle pulse, `full` is only high with `done`, and `hit` and `full` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_start | input | 1 | Start a whole-table clear (taken when idle) |
| req_valid | input | 1 | Request strobe, taken while ready is high |
| req_op | input | 2 | Request kind: lookup, insert, delete |
| req_mac | input | 48 | Address to look up, insert or delete |
| req_skip | input | 1 | Skip flag stored by an insert |
| req_discard | input | 1 | Discard flag stored by an insert |
| ready | output | 1 | Idle with a cleared table; a request may be taken |
| done | output | 1 | One-cycle end-of-request pulse |
| hit | output | 1 | Address was found (valid with done) |
| full | output | 1 | Insert found no free entry within the hop limit |
| rsp_skip | output | 1 | Skip flag of the matched entry on a lookup hit |
| rsp_discard | output | 1 | Discard flag of the matched entry on a lookup hit |

## Verification
The bench builds the filter with HOP_LIMIT set to 4. With that limit, four addresses that differ only in their first byte, and so share a start index, fill a whole probe window. This makes the full report and the hop-limit miss cheap to reach, and each walk length shows up in the timing of `done`. The table depth stays at 2048, so the bench searches for addresses that hash to index 2047, to index 0, and to a chosen index inside an occupied run. This lets it exercise the wrap, the hash fields, and the way a deleted entry cuts a run short.

// File: rtl/mhf_pkg.sv
`timescale 1ns/1ps
package mhf_pkg;

   localparam int MHF_MAC_W = 48;
   localparam int MHF_IDX_W = 11;
   localparam int MHF_KEY_W = 33;   // address bits that feed the hash
   localparam int MHF_ENT_W = 64;

   typedef enum logic [1:0] {
      OP_LOOKUP = 2'b00,
      OP_INSERT = 2'b01,
      OP_DELETE = 2'b10,
      OP_LOOK_B = 2'b11
   } mhf_op_e;

   typedef struct packed {
      logic [12:0]          pad;
      logic [MHF_MAC_W-1:0] mac;
      logic                 discard;
      logic                 skip;
      logic                 valid;
   } mhf_entry_t;

endpackage

// File: rtl/mhf_hash.sv
`timescale 1ns/1ps
module mhf_hash
   import mhf_pkg::*;
#(
   parameter int KEY_W = MHF_KEY_W,
   parameter int IDX_W = MHF_IDX_W
) (
   input  logic [KEY_W-1:0] key,   // {mac[39], mac[31:0]}
   output logic [IDX_W-1:0] idx
);
   localparam int LOW_BYTES = (KEY_W - 1) / 8;

   generate
      if (KEY_W != 33 || IDX_W != 11) begin : g_bad_cfg
         $error("mhf_hash: the index function is defined for a 33-bit key and 11-bit index");
      end
   endgenerate

   logic [8*LOW_BYTES-1:0] lrev;
   logic                   h0;
   logic [5:0]             f0;
   logic [8:0]             f1, f2, f3;
   logic [14:0]            wide;

   // bit order reversed inside each byte of the low word
   for (genvar b = 0; b < LOW_BYTES; b++) begin : g_byte
      for (genvar i = 0; i < 8; i++) begin : g_bit
         assign lrev[b*8+i] = key[b*8+7-i];
      end
   end

   assign h0   = key[KEY_W-1];
   assign f0   = lrev[7:2];
   assign f1   = {lrev[14:8], lrev[1:0]};
   assign f2   = lrev[23:15];
   assign f3   = {h0, lrev[31:24]};
   assign wide = {f0, f1 ^ f2 ^ f3};
   assign idx  = wide[IDX_W-1:0];

endmodule

// File: rtl/mhf_table.sv
`timescale 1ns/1ps
module mhf_table #(
   parameter int AW = 11,
   parameter int DW = 64
) (
   input  logic          clk,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (rd_en) rd_data <= mem[rd_addr];
   end

endmodule

// File: rtl/mhf_ctrl.sv
`timescale 1ns/1ps
module mhf_ctrl
   import mhf_pkg::*;
#(
   parameter int HOP_LIMIT = 12,
   parameter int IDX_W     = MHF_IDX_W,
   parameter int HOP_W     = $clog2(HOP_LIMIT + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_start,
   input  logic                 req_valid,
   input  logic [1:0]           req_op,
   input  logic [MHF_MAC_W-1:0] req_mac,
   input  logic                 req_skip,
   input  logic                 req_discard,
   input  logic [IDX_W-1:0]     hash_idx,
   input  logic [MHF_ENT_W-1:0] rd_data,
   output logic                 rd_en,
   output logic [IDX_W-1:0]     rd_addr,
   output logic                 wr_en,
   output logic [IDX_W-1:0]     wr_addr,
   output logic [MHF_ENT_W-1:0] wr_data,
   output logic                 ready,
   output logic                 done,
   output logic                 hit,
   output logic                 full,
   output logic                 rsp_skip,
   output logic                 rsp_discard,
   output logic [HOP_W-1:0]     probe_cnt
);
   typedef enum logic [1:0] {S_IDLE, S_CLEAR, S_PROBE} state_e;

   state_e               state;
   logic                 cleared;
   logic [IDX_W-1:0]     idx_q, clr_cnt;
   logic [HOP_W-1:0]     hops_q;
   mhf_op_e              op_q;
   logic [MHF_MAC_W-1:0] mac_q;
   logic                 skip_q, disc_q;

   mhf_entry_t ent, nent;
   logic accept, is_ins, is_del, is_empty, is_match, last_hop, decide;

   assign ready     = (state == S_IDLE) && cleared;
   assign accept    = ready && req_valid && !clr_start;
   assign is_ins    = (op_q == OP_INSERT);
   assign is_del    = (op_q == OP_DELETE);
   assign probe_cnt = hops_q;

   always_comb begin
      ent      = mhf_entry_t'(rd_data);
      nent     = '{pad: '0, mac: mac_q, discard: disc_q, skip: skip_q, valid: 1'b1};
      is_empty = !ent.valid;
      is_match = ent.valid && ({ent.pad, ent.mac} == {nent.pad, nent.mac});
      last_hop = (hops_q == HOP_W'(HOP_LIMIT - 1));
      decide   = is_empty || is_match || last_hop;

      rd_en   = 1'b0;
      rd_addr = idx_q + 1'b1;
      if (accept) begin
         rd_en   = 1'b1;
         rd_addr = hash_idx;
      end else if (state == S_PROBE && !decide) begin
         rd_en = 1'b1;
      end

      wr_en   = 1'b0;
      wr_addr = idx_q;
      wr_data = '0;
      if (state == S_CLEAR) begin
         wr_en   = 1'b1;
         wr_addr = clr_cnt;
      end else if (state == S_PROBE) begin
         if (is_ins && (is_empty || is_match)) begin
            wr_en   = 1'b1;
            wr_data = nent;
         end else if (is_del && is_match) begin
            wr_en = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         cleared     <= 1'b0;
         idx_q       <= '0;
         clr_cnt     <= '0;
         hops_q      <= '0;
         op_q        <= OP_LOOKUP;
         mac_q       <= '0;
         skip_q      <= 1'b0;
         disc_q      <= 1'b0;
         done        <= 1'b0;
         hit         <= 1'b0;
         full        <= 1'b0;
         rsp_skip    <= 1'b0;
         rsp_discard <= 1'b0;
      end else begin
         done        <= 1'b0;
         hit         <= 1'b0;
         full        <= 1'b0;
         rsp_skip    <= 1'b0;
         rsp_discard <= 1'b0;
         case (state)
            S_IDLE: begin
               if (clr_start) begin
                  state   <= S_CLEAR;
                  clr_cnt <= '0;
                  cleared <= 1'b0;
               end else if (accept) begin
                  state  <= S_PROBE;
                  idx_q  <= hash_idx;
                  hops_q <= '0;
                  op_q   <= mhf_op_e'(req_op);
                  mac_q  <= req_mac;
                  skip_q <= req_skip;
                  disc_q <= req_discard;
               end
            end
            S_CLEAR: begin
               clr_cnt <= clr_cnt + 1'b1;
               if (clr_cnt == {IDX_W{1'b1}}) begin
                  state   <= S_IDLE;
                  cleared <= 1'b1;
               end
            end
            S_PROBE: begin
               if (decide) begin
                  state       <= S_IDLE;
                  done        <= 1'b1;
                  hit         <= is_match;
                  full        <= is_ins && !is_empty && !is_match;
                  rsp_skip    <= !is_ins && !is_del && is_match && ent.skip;
                  rsp_discard <= !is_ins && !is_del && is_match && ent.discard;
               end else begin
                  idx_q  <= idx_q + 1'b1;
                  hops_q <= hops_q + 1'b1;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mac_hash_filter.sv
`timescale 1ns/1ps
module mac_hash_filter
   import mhf_pkg::*;
#(
   parameter int HOP_LIMIT = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr_start,
   input  logic        req_valid,
   input  logic [1:0]  req_op,
   input  logic [47:0] req_mac,
   input  logic        req_skip,
   input  logic        req_discard,
   output logic        ready,
   output logic        done,
   output logic        hit,
   output logic        full,
   output logic        rsp_skip,
   output logic        rsp_discard
);
   localparam int IDX_W = MHF_IDX_W;
   localparam int DEPTH = 1 << IDX_W;
   localparam int HOP_W = $clog2(HOP_LIMIT + 1);

   generate
      if (HOP_LIMIT < 1 || HOP_LIMIT > DEPTH) begin : g_bad_hops
         $error("mac_hash_filter: HOP_LIMIT must lie in 1..table depth");
      end
   endgenerate

   logic [IDX_W-1:0]     hash_idx, rd_addr, wr_addr;
   logic [MHF_ENT_W-1:0] rd_data, wr_data;
   logic                 rd_en, wr_en;
   logic [HOP_W-1:0]     probe_cnt;

   mhf_hash #(.KEY_W(MHF_KEY_W), .IDX_W(IDX_W)) u_hash (
      .key ({req_mac[39], req_mac[31:0]}),
      .idx (hash_idx)
   );

   mhf_table #(.AW(IDX_W), .DW(MHF_ENT_W)) u_table (
      .clk     (clk),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

   mhf_ctrl #(.HOP_LIMIT(HOP_LIMIT), .IDX_W(IDX_W), .HOP_W(HOP_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_start   (clr_start),
      .req_valid   (req_valid),
      .req_op      (req_op),
      .req_mac     (req_mac),
      .req_skip    (req_skip),
      .req_discard (req_discard),
      .hash_idx    (hash_idx),
      .rd_data     (rd_data),
      .rd_en       (rd_en),
      .rd_addr     (rd_addr),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .ready       (ready),
      .done        (done),
      .hit         (hit),
      .full        (full),
      .rsp_skip    (rsp_skip),
      .rsp_discard (rsp_discard),
      .probe_cnt   (probe_cnt)
   );

endmodule

// File: rtl/mhf_checker.sv
`timescale 1ns/1ps
module mhf_checker #(
   parameter int HOP_LIMIT = 12,
   parameter int HOP_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_start,
   input logic             req_valid,
   input logic             ready,
   input logic             done,
   input logic             hit,
   input logic             full,
   input logic             rsp_skip,
   input logic             rsp_discard,
   input logic [HOP_W-1:0] probe_cnt
);
   localparam int LAT_W = $clog2(HOP_LIMIT + 2) + 1;

   logic [LAT_W-1:0] lat_q;
   logic             busy_q;
   logic             take;

   assign take = ready && req_valid && !clr_start;

   // edges counted since the accepting edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q  <= '0;
         busy_q <= 1'b0;
      end else if (take) begin
         lat_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q && !done) begin
         lat_q <= lat_q + 1'b1;
      end else if (done) begin
         busy_q <= 1'b0;
      end
   end

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_full_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> (done && !hit));

   assert_rsp_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_skip || rsp_discard) |-> (done && hit));

   assert_take_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ready) |=> !ready);

   assert_latency_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_q && lat_q >= 1 && lat_q <= LAT_W'(HOP_LIMIT)));

   assert_full_at_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && full) |-> (lat_q == LAT_W'(HOP_LIMIT)));

   assert_probe_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      probe_cnt < HOP_W'(HOP_LIMIT));

endmodule

bind mac_hash_filter mhf_checker #(.HOP_LIMIT(HOP_LIMIT), .HOP_W(HOP_W)) u_mhf_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clr_start   (clr_start),
   .req_valid   (req_valid),
   .ready       (ready),
   .done        (done),
   .hit         (hit),
   .full        (full),
   .rsp_skip    (rsp_skip),
   .rsp_discard (rsp_discard),
   .probe_cnt   (probe_cnt)
);

// File: tb/mac_hash_filter_bench.sv
`timescale 1ns/1ps
module mac_hash_filter_bench;
   localparam int HOPS = 4;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        clr_start = 1'b0, req_valid = 1'b0, req_skip = 1'b0, req_discard = 1'b0;
   logic [1:0]  req_op = 2'b00;
   logic [47:0] req_mac = '0;
   logic        ready, done, hit, full, rsp_skip, rsp_discard;

   always #2.5 clk = ~clk;

   mac_hash_filter #(.HOP_LIMIT(HOPS)) u_mac_hash_filter (
      .clk(clk), .rst_n(rst_n), .clr_start(clr_start), .req_valid(req_valid),
      .req_op(req_op), .req_mac(req_mac), .req_skip(req_skip), .req_discard(req_discard),
      .ready(ready), .done(done), .hit(hit), .full(full),
      .rsp_skip(rsp_skip), .rsp_discard(rsp_discard)
   );

   typedef struct {
      logic  hit, full, skp, dsc;
      int    lat, acc;
      string tag;
   } exp_t;

   exp_t q[$];
   exp_t mon_e;
   int   total = 0, bad = 0, cyc = 0, mon_lat;

   always @(posedge clk) cyc <= cyc + 1;

   // R3 index model
   function automatic logic [10:0] ref_hash(input logic [47:0] m);
      logic [31:0] l;
      logic [8:0]  x;
      for (int b = 0; b < 4; b++)
         for (int i = 0; i < 8; i++) l[b*8+i] = m[b*8+7-i];
      x = {l[14:8], l[1:0]} ^ l[23:15] ^ {m[39], l[31:24]};
      return {l[3:2], x};
   endfunction

   function automatic logic [47:0] find_mac(input logic [47:0] base, input int target);
      for (int k = 0; k < 65536; k++) begin
         logic [47:0] m;
         m = {base[47:16], k[15:0]};
         if (ref_hash(m) == target[10:0]) return m;
      end
      return base;
   endfunction

   task automatic check(input logic ok, input string what, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
      end
   endtask

   // driver: one request, expected outcome pushed to the scoreboard
   task automatic send(input logic [1:0] op, input logic [47:0] m, input logic s, input logic d,
                       input logic eh, input logic ef, input logic es, input logic ed,
                       input int el, input string tag);
      exp_t e;
      @(negedge clk);
      while (!ready) @(negedge clk);
      req_op = op; req_mac = m; req_skip = s; req_discard = d; req_valid = 1'b1;
      e.hit = eh; e.full = ef; e.skp = es; e.dsc = ed; e.lat = el; e.acc = cyc + 1; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
      while (q.size() != 0) @(negedge clk);
   endtask

   task automatic do_clear(input logic with_req, input string tag);
      int st;
      @(negedge clk);
      clr_start = 1'b1; req_valid = with_req; req_op = 2'b01; req_mac = 48'h0A0B0C0D0E0F;
      st = cyc + 1;
      @(negedge clk);
      clr_start = 1'b0; req_valid = 1'b0;
      while (!ready) @(negedge clk);
      check(cyc - st == 2048, tag, cyc - st, 2048);
   endtask

   // monitor: pops and compares on every done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (q.size() == 0) begin
            total++; bad++;
            $display("FAIL R10/R11 unexpected done actual=1 expected=0");
         end else begin
            mon_e = q.pop_front();
            mon_lat = cyc - mon_e.acc;
            total++;
            if (hit !== mon_e.hit || full !== mon_e.full || rsp_skip !== mon_e.skp ||
                rsp_discard !== mon_e.dsc || mon_lat != mon_e.lat) begin
               bad++;
               $display("FAIL %s actual hit=%0b full=%0b skip=%0b disc=%0b lat=%0d expected hit=%0b full=%0b skip=%0b disc=%0b lat=%0d",
                        mon_e.tag, hit, full, rsp_skip, rsp_discard, mon_lat,
                        mon_e.hit, mon_e.full, mon_e.skp, mon_e.dsc, mon_e.lat);
            end
         end
      end
   end

   initial begin
      #(5.0 * 150000);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [47:0] a, d, e, w0, w1, z;
      logic [47:0] c [5];
      a  = find_mac(48'h02_11_22_33_00_00, 500);
      c[0] = find_mac(48'h10_44_55_66_00_00, 100);
      for (int k = 1; k < 5; k++) c[k] = {8'h10 + 8'(k), c[0][39:0]};
      d  = find_mac(48'h20_77_88_99_00_00, 103);
      e  = find_mac(48'h30_12_34_56_00_00, 700);
      w0 = find_mac(48'h40_9A_BC_DE_00_00, 2047);
      w1 = {8'h41, w0[39:0]};
      z  = find_mac(48'h50_13_57_9B_00_00, 0);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(ready == 1'b0 && done == 1'b0, "R1 reset state ready/done", {ready, done}, 0);
      // R1 R10: requests before the first clear are ignored
      req_valid = 1'b1; req_op = 2'b01; req_mac = a; req_skip = 1'b1;
      repeat (6) @(negedge clk);
      req_valid = 1'b0;
      check(ready == 1'b0, "R1 not ready before clear", ready, 0);

      do_clear(1'b0, "R2 clear length");
      send(2'b00, a, 0, 0, 0, 0, 0, 0, 1, "R1 R4 lookup miss on fresh table");
      send(2'b01, a, 1, 0, 0, 0, 0, 0, 1, "R8 insert into empty entry");
      send(2'b00, a, 0, 0, 1, 0, 1, 0, 1, "R4 lookup hit returns flags");

      send(2'b01, c[0], 0, 0, 0, 0, 0, 0, 1, "R5 chain insert 1");
      send(2'b01, c[1], 0, 0, 0, 0, 0, 0, 2, "R5 chain insert 2");
      send(2'b01, c[2], 0, 0, 0, 0, 0, 0, 3, "R5 chain insert 3");
      send(2'b01, c[3], 1, 1, 0, 0, 0, 0, 4, "R5 chain insert 4");
      send(2'b01, c[4], 0, 1, 0, 1, 0, 0, 4, "R7 insert reports full");
      send(2'b11, c[4], 0, 0, 0, 0, 0, 0, 4, "R7 R10 alt lookup misses at limit");
      send(2'b00, c[3], 0, 0, 1, 0, 1, 1, 4, "R5 lookup hit at last probe");
      send(2'b00, d, 0, 0, 0, 0, 0, 0, 2, "R3 start index inside occupied run");

      send(2'b10, c[1], 0, 0, 1, 0, 0, 0, 2, "R9 delete present");
      send(2'b00, c[1], 0, 0, 0, 0, 0, 0, 2, "R9 deleted address misses");
      send(2'b00, c[3], 0, 0, 0, 0, 0, 0, 2, "R9 walk stops at zeroed entry");
      send(2'b10, e, 0, 0, 0, 0, 0, 0, 1, "R9 delete absent");
      send(2'b10, c[1], 0, 0, 0, 0, 0, 0, 2, "R9 delete again is no-op");
      send(2'b01, c[4], 0, 1, 0, 0, 0, 0, 2, "R8 insert reuses freed entry");
      send(2'b00, c[4], 0, 0, 1, 0, 0, 1, 2, "R8 reused entry holds flags");
      send(2'b01, c[0], 1, 0, 1, 0, 0, 0, 1, "R8 insert overwrites match");
      send(2'b00, c[0], 0, 0, 1, 0, 1, 0, 1, "R8 overwritten flags visible");
      send(2'b00, a, 0, 0, 1, 0, 1, 0, 1, "R4 unrelated entry intact");

      send(2'b01, w0, 0, 1, 0, 0, 0, 0, 1, "R6 insert at last index");
      send(2'b01, w1, 1, 1, 0, 0, 0, 0, 2, "R6 insert wraps to index 0");
      send(2'b00, z, 0, 0, 0, 0, 0, 0, 2, "R6 index 0 occupied by wrapped entry");
      send(2'b00, w1, 0, 0, 1, 0, 1, 1, 2, "R6 lookup across wrap");

      do_clear(1'b1, "R2 R10 clear wins over request");
      send(2'b00, a, 0, 0, 0, 0, 0, 0, 1, "R2 cleared entry misses");
      send(2'b00, w1, 0, 0, 0, 0, 0, 0, 1, "R2 R10 dropped insert absent");
      send(2'b00, 48'h0A0B0C0D0E0F, 0, 0, 0, 0, 0, 0, 1, "R10 request dropped during clear");

      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule